// File: doc/BRIEF.md
# Request/Ready Bus Master Adapter

This block lets a DMA sequencer move 1, 2 or 4 bytes through a shared 8-bit synchronous bus without knowing how that bus is arbitrated or how wide it is. The sequencer raises `req` with the direction, size, address and write data. The adapter asks the bus arbiter for ownership and waits for the grant. It then runs one byte beat per cycle at incrementing addresses and answers with a one-cycle `rdy` pulse.

Data is little-endian. Byte lane k of `wdata` and `rdata` belongs to address `addr + k`. The sequencer must hold its inputs from the first edge with `req` high until the edge that sees `rdy`, so the adapter does not register them. If `req` is still high in the cycle after `rdy`, a new transfer starts.

The controller has four states:
- **IDLE**: waits for `req`. Transition IDLE→ARB when `req` is sampled high.
- **ARB**: holds `bus_req`. It stays in ARB while `bus_gnt` is low, and goes ARB→BEAT when the grant is sampled.
- **BEAT**: drives one bus beat per cycle. It stays in BEAT until the last beat, then goes BEAT→DONE.
- **DONE**: drives `rdy` and releases the bus. DONE→IDLE is unconditional.

Top module: `bus_master_adapter`

## Requirements
- R1: After reset, `rdy`, `bus_req`, `bus_stb` and `bus_we` are low, and they stay low while `req` is low.
- R2: `bus_req` goes high in the cycle after the edge that samples `req` high in IDLE. A beat (`bus_stb` high) only ever occurs while `bus_req` is high.
- R3: `size` encodes the byte count: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, and the reserved code 2'b11 also gives 4. Exactly that many beats run, and no other address is written.
- R4: Beat k (counting from 0) drives `bus_addr = addr + k`, wrapping at the address width. On writes it drives `bus_wdata = wdata[8k+7:8k]`. Beats run back to back.
- R5: `bus_we` equals `rw` (1 = write, 0 = read) on every beat of a transfer.
- R6: On a read, `rdata[8k+7:8k]` holds the bus byte read on beat k while `rdy` is high. Bytes above the transfer size read as zero.
- R7: `rdy` is high for exactly one cycle per transfer, and it is low again in the following cycle.
- R8: `bus_req` stays high from the grant through the last beat and is low in the `rdy` cycle.
- R9: No beat starts until `bus_gnt` has been sampled high. With a grant given n cycles after `bus_req` rises, the first beat is in cycle n+2 after `req` is presented.
- R10: If `req` stays high after `rdy`, a new transfer starts with the same latency as one from an idle bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Sequencer transfer request |
| rw | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Byte count code |
| addr | input | ADDR_W | Start byte address |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Read data, valid while rdy is high |
| rdy | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_stb | output | 1 | Beat strobe, one byte per cycle |
| bus_we | output | 1 | Beat direction |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_wdata | output | 8 | Beat write byte |
| bus_rdata | input | 8 | Beat read byte, sampled at the beat's edge |

## Verification
The assertions check the following on every cycle:
- strobes occur only under `bus_req`;
- no beat follows a cycle in which the grant was withheld;
- `rdy` is a lone pulse and is released from the bus;
- beat addresses step by one with a steady direction, and the beats are contiguous.

Only the bench's scenarios can show the rest:
- beat counts per size code;
- the lane that carries each byte;
- the zero-filled upper read bytes;
- the exact grant-to-beat latency;
- that bytes beyond the transfer are untouched in memory;
- back-to-back starts when `req` stays high.

// File: rtl/bma_pkg.sv
package bma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_BEAT,
        ST_DONE
    } bma_state_e;

    localparam int LANE_W   = 8;
    localparam int MAX_BYTES = 4;
    localparam int IDX_W    = $clog2(MAX_BYTES);

    function automatic logic [IDX_W-1:0] final_index(input logic [1:0] sz);
        logic [IDX_W-1:0] r;
        unique case (sz)
            2'b00:   r = IDX_W'(0);
            2'b01:   r = IDX_W'(1);
            default: r = IDX_W'(MAX_BYTES - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bma_fsm.sv
module bma_fsm
    import bma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       gnt,
    input  logic       last_beat,
    output bma_state_e state,
    output logic       own_bus,
    output logic       beat,
    output logic       done
);

    bma_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)       state_d = ST_ARB;
            ST_ARB:  if (gnt)       state_d = ST_BEAT;
            ST_BEAT: if (last_beat) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        own_bus = 1'b0;
        beat    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARB:  own_bus = 1'b1;
            ST_BEAT: begin
                own_bus = 1'b1;
                beat    = 1'b1;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bma_beat_ctr.sv
module bma_beat_ctr
    import bma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [1:0]       size,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;

    assign last = (idx_q == final_index(size));
    assign idx  = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             idx_q <= '0;
        else if (advance) begin
            if (last)           idx_q <= '0;
            else                idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/bma_lanes.sv
module bma_lanes
    import bma_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          capture,
    input  logic [IDX_W-1:0]              idx,
    input  logic [MAX_BYTES*LANE_W-1:0]   wdata,
    input  logic [LANE_W-1:0]             lane_in,
    output logic [LANE_W-1:0]             lane_out,
    output logic [MAX_BYTES*LANE_W-1:0]   rdata
);

    assign lane_out = wdata[idx*LANE_W +: LANE_W];

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
        logic [LANE_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              byte_q <= '0;
            else if (clear)                          byte_q <= '0;
            else if (capture && idx == IDX_W'(b))    byte_q <= lane_in;
        end
        assign rdata[b*LANE_W +: LANE_W] = byte_q;
    end

endmodule

// File: rtl/bus_master_adapter.sv
module bus_master_adapter
    import bma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rdy,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata
);

    bma_state_e       state;
    logic             own_bus, beat, done, last;
    logic [IDX_W-1:0] idx;

    bma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .gnt       (bus_gnt),
        .last_beat (last),
        .state     (state),
        .own_bus   (own_bus),
        .beat      (beat),
        .done      (done)
    );

    bma_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (beat),
        .size    (size),
        .idx     (idx),
        .last    (last)
    );

    bma_lanes u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE && req),
        .capture  (beat && !rw),
        .idx      (idx),
        .wdata    (wdata),
        .lane_in  (bus_rdata),
        .lane_out (bus_wdata),
        .rdata    (rdata)
    );

    assign bus_req  = own_bus;
    assign bus_stb  = beat;
    assign bus_we   = beat & rw;
    assign bus_addr = addr + ADDR_W'(idx);
    assign rdy      = done;

endmodule

// File: rtl/bma_chk.sv
module bma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr
);

    // R2
    stb_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> bus_req);

    // R9
    no_beat_without_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_stb && !bus_gnt) |=> !bus_stb);

    // R7
    rdy_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R8
    release_on_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (!bus_req && !bus_stb));

    // R8
    beats_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |=> (bus_stb || rdy));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && $past(bus_stb)) |-> (bus_addr == $past(bus_addr) + 1'b1));

    // R5
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && $past(bus_stb)) |-> (bus_we == $past(bus_we)));

    // R3
    rdy_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> $past(bus_stb));

endmodule

bind bus_master_adapter bma_chk #(.ADDR_W(ADDR_W)) u_bma_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_stb  (bus_stb),
    .bus_we   (bus_we),
    .bus_addr (bus_addr)
);

// File: tb/bus_master_adapter_test.sv
module bus_master_adapter_test;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              rw = 1'b0;
    logic [1:0]        size = 2'b00;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rdy;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              bus_stb;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;

    logic [7:0] mem [0:255];
    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_master_adapter #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .size(size),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    assign bus_rdata = mem[bus_addr[7:0]];
    always @(posedge clk) if (bus_stb && bus_we) mem[bus_addr[7:0]] <= bus_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit rw_i, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, input int dly, input bit keep, input bit cont);
        int nb_exp, nb, cyc, reqcnt;
        bit done, gnt_prev;
        logic [31:0] exp_rd;
        logic [7:0] beyond;
        nb_exp = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        exp_rd = '0;
        for (int i = 0; i < nb_exp; i++) exp_rd[8*i +: 8] = mem[8'(a + 16'(i))];
        beyond = mem[8'(a + 16'(nb_exp))];
        if (!cont) @(negedge clk);
        req = 1'b1; rw = rw_i; size = sz; addr = a; wdata = wd;
        cyc = 0; nb = 0; reqcnt = 0; done = 0; gnt_prev = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) chk(bus_req === 1'b1, cont ? "R10 restart bus_req" : "R2 bus_req raised", 32'(bus_req), 1);
            if (bus_stb) begin
                chk(gnt_prev, "R9 beat only after grant", 0, 1);
                if (nb == 0) chk(cyc == 2 + dly, "R9 first beat cycle", cyc, 2 + dly);
                chk(bus_addr == 16'(a + 16'(nb)), "R4 beat address", 32'(bus_addr), 32'(16'(a + 16'(nb))));
                chk(bus_we == rw_i, "R5 beat direction", 32'(bus_we), 32'(rw_i));
                if (rw_i) chk(bus_wdata == wd[8*nb +: 8], "R4 write lane", 32'(bus_wdata), 32'(wd[8*nb +: 8]));
                nb++;
            end
            if (rdy) begin
                done = 1;
                chk(nb == nb_exp, "R3 beat count", nb, nb_exp);
                chk(!bus_req, "R8 bus released at rdy", 32'(bus_req), 0);
                if (!rw_i) chk(rdata == exp_rd, "R6 read data", rdata, exp_rd);
                if (!keep) req = 1'b0;
            end
            if (bus_req) reqcnt++;
            gnt_prev = bus_req && (reqcnt > dly);
            bus_gnt = gnt_prev;
        end
        chk(done, "R7 rdy seen", 32'(done), 1);
        if (rw_i) begin
            for (int i = 0; i < nb_exp; i++)
                chk(mem[8'(a + 16'(i))] == wd[8*i +: 8], "R4 memory byte", 32'(mem[8'(a + 16'(i))]), 32'(wd[8*i +: 8]));
        end
        chk(mem[8'(a + 16'(nb_exp))] == beyond, "R3 byte past transfer untouched",
            32'(mem[8'(a + 16'(nb_exp))]), 32'(beyond));
        @(negedge clk);
        chk(!rdy, "R7 rdy low next cycle", 32'(rdy), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        chk(!rdy && !bus_req && !bus_stb && !bus_we, "R1 reset outputs", {rdy, bus_req, bus_stb, bus_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rdy && !bus_req && !bus_stb && !bus_we, "R1 idle outputs", {rdy, bus_req, bus_stb, bus_we}, 0);

        for (int r = 1; r >= 0; r--)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 3; d++)
                    xfer(r[0], s[1:0], 16'(16'h0040 + s * 16 + d * 5), 32'h9A00_0000 + 32'(s * 4097 + d * 313 + 17), d, 0, 0);

        xfer(1'b1, 2'b10, 16'h01FE, 32'hC3B2A190, 1, 0, 0);
        xfer(1'b0, 2'b10, 16'h01FE, 32'h0, 0, 0, 0);
        xfer(1'b0, 2'b00, 16'h01FF, 32'h0, 2, 0, 0);

        xfer(1'b1, 2'b01, 16'h0080, 32'h0000_5AA5, 0, 1, 0);
        xfer(1'b0, 2'b01, 16'h0080, 32'h0, 1, 1, 1);
        xfer(1'b0, 2'b11, 16'h007F, 32'h0, 0, 0, 1);

        repeat (3) @(negedge clk);
        chk(!rdy && !bus_req && !bus_stb, "R1 quiet after last transfer", {rdy, bus_req, bus_stb}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule